// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Event Detection

This block turns an asynchronous serial line into data words. It runs at sixteen samples per bit, with the sample rate set by a runtime prescaler. Frame shape is chosen at run time: the word length (5 to 9 bits), an optional parity bit in one of four flavours, and one or two stop bits. Each finished frame gives a one-cycle write strobe with the word, to be pushed into a downstream buffer. The buffer itself lies outside this block.

The receiver also drives one-cycle event pulses. These report a framing error, a parity error, an overrun (a word finished while the buffer was full), a line break, a received word equal to a programmed compare word, and a receiver timeout after a programmed number of silent bit periods. A loopback select feeds the local transmitter's output in place of the external pin. An optional stable-sample filter strips short glitches from the incoming line.

Top module: `uart_rx_core`

## Requirements
- R1: After a synchronous active-low reset, every output is 0 and the receiver waits for a start bit.
- R2: Data bits are taken least significant first. A word length below 5 counts as 5 and above 9 counts as 9. Word bits at and above the length read 0. Each complete frame gives exactly one `rx_word_we` pulse.
- R3: `parity_mode` selects the parity: 3'b000 none, 3'b001 odd (total ones including the parity bit is odd), 3'b010 even, 3'b100 parity bit always 0, 3'b101 parity bit always 1. Any other code means no parity bit. A mismatch pulses `parity_err` with the word strobe.
- R4: `two_stop`=1 expects two stop bits. If any expected stop bit samples low, `frame_err` pulses together with the word. After a low final stop bit, no new start is accepted until the line has been high.
- R5: A falling edge whose line is high again at the middle of the start bit (8th of 16 samples) is discarded with no event.
- R6: A frame that completes while `buf_full`=1 pulses `overrun` and gives no `rx_word_we`.
- R7: `match_hit` pulses when a completed word equals `match_word`.
- R8: `line_break` pulses once after 13 bit periods of continuous low line. It is rearmed by a high line.
- R9: With `timeout_bits`=N>0, `rx_timeout` pulses once N bit periods after the last stop sample of a frame. It does not pulse again until another frame completes. N=0 disables it.
- R10: With `loop_en`=1 the receiver reads `tx_loop` and ignores `rx_pin`. With `loop_en`=0, `tx_loop` has no effect.
- R11: With `filt_en`=1 the line only changes after 8 consecutive equal clock samples, so a low pulse of 7 clocks or less is not seen. With `filt_en`=0 such a pulse is seen.
- R12: Unless both `glob_en` and `rx_en` are 1, no frame is received and no event pulses.
- R13: One bit period lasts 16*(`prescale`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_pin | input | 1 | External serial input |
| tx_loop | input | 1 | Local transmitter output, used in loopback |
| loop_en | input | 1 | Select `tx_loop` as the line |
| filt_en | input | 1 | Enable the glitch filter |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| prescale | input | 16 | Sample-rate divider |
| word_len | input | 4 | Data bits per frame |
| parity_mode | input | 3 | Parity selection code |
| two_stop | input | 1 | Two stop bits |
| timeout_bits | input | 6 | Silent bit periods before timeout, 0 off |
| match_word | input | 9 | Compare word |
| buf_full | input | 1 | Downstream buffer is full |
| rx_word | output | 9 | Last received word |
| rx_word_we | output | 1 | Word write strobe |
| frame_err | output | 1 | Framing error pulse |
| parity_err | output | 1 | Parity error pulse |
| overrun | output | 1 | Overrun pulse |
| line_break | output | 1 | Line break pulse |
| match_hit | output | 1 | Compare match pulse |
| rx_timeout | output | 1 | Receiver timeout pulse |

## Verification
A wrong bit index or sampling phase shows up as a wrong `rx_word` at the end of the same frame. It appears about half a bit after the last data bit, so every frame sent exposes it. A frame state machine stuck in the wrong state gives either a missing strobe or a spurious pulse within one frame time. A wrong timeout or break counter gives a pulse early, late, repeated or missing, seen within a few bit periods of the quiet line. The bench compares every pulse, in order, against a queue of expected events.

// File: rtl/uart_rx_pkg.sv
// Shared constants, state type and helpers for the serial receiver.
// Assumes a power-of-two oversampling ratio.
package uart_rx_pkg;
    localparam int OSR = 16;

    localparam logic [2:0] PAR_NONE = 3'b000;
    localparam logic [2:0] PAR_ODD  = 3'b001;
    localparam logic [2:0] PAR_EVEN = 3'b010;
    localparam logic [2:0] PAR_LOW  = 3'b100;
    localparam logic [2:0] PAR_HIGH = 3'b101;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_WAITHI
    } rx_state_e;

    // True when the parity code calls for a parity bit in the frame.
    function automatic logic par_present(input logic [2:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
               (mode == PAR_LOW) || (mode == PAR_HIGH);
    endfunction
endpackage

// File: rtl/rx_line_cond.sv
// Line conditioning: picks the pin or the loopback line, then brings it
// into the clock domain through two flops. An optional filter changes its
// output only after FILT_LEN equal samples in a row.
// Assumes the idle line is high.
module rx_line_cond #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic tx_loop,
    input  logic loop_en,
    input  logic filt_en,
    output logic line
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                filt_q;

    // Source select and two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[0], loop_en ? tx_loop : rx_pin};
    end

    // Sample history plus a filtered level that moves on a uniform history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)       filt_q <= 1'b1;
            else if (~|hist_q) filt_q <= 1'b0;
        end
    end

    assign line = filt_en ? filt_q : sync_q[1];
endmodule

// File: rtl/rx_tick_gen.sv
// Sample tick generator: one tick every (prescale+1) clocks. The restart
// input realigns the phase to a detected start edge.
module rx_tick_gen #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] prescale,
    input  logic          restart,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == prescale);

    // Divider counter, cleared on wrap or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (restart || tick) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame engine: start qualification at mid-bit, LSB-first data capture,
// parity and stop checks, and the word/error pulses at the final stop
// sample. Assumes DW >= 5 and a conditioned line that idles high.
module rx_frame_fsm import uart_rx_pkg::*; #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          line,
    input  logic          tick,
    input  logic [3:0]    word_len,
    input  logic [2:0]    parity_mode,
    input  logic          two_stop,
    input  logic [DW-1:0] match_word,
    input  logic          buf_full,
    output logic          restart,
    output logic          frame_done,
    output logic [DW-1:0] rx_word,
    output logic          word_we,
    output logic          frame_err,
    output logic          parity_err,
    output logic          overrun,
    output logic          match_hit
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DW + 1);
    localparam logic [TW-1:0] T_MID = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] T_END = TW'(OSR - 1);

    rx_state_e     st;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bidx, nbits;
    logic [DW-1:0] shreg;
    logic          par_acc, pbit, stop_bad;
    logic          sample, last_stop, stop_fail, exp_par, has_par;

    // Effective word length, clamped to the legal range.
    always_comb begin
        if (int'(word_len) < 5)       nbits = BW'(5);
        else if (int'(word_len) > DW) nbits = BW'(DW);
        else                          nbits = BW'(word_len);
    end

    // Expected parity bit for the selected code.
    always_comb begin
        case (parity_mode)
            PAR_ODD:  exp_par = ~par_acc;
            PAR_EVEN: exp_par = par_acc;
            PAR_HIGH: exp_par = 1'b1;
            default:  exp_par = 1'b0;
        endcase
    end

    assign has_par    = par_present(parity_mode);
    assign sample     = tick && (tcnt == T_END);
    assign restart    = active && (st == S_IDLE) && !line;
    assign last_stop  = sample && (((st == S_STOP1) && !two_stop) || (st == S_STOP2));
    assign stop_fail  = !line || ((st == S_STOP2) && stop_bad);
    assign frame_done = active && last_stop;

    // Frame sequencing and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            pbit     <= 1'b0;
            stop_bad <= 1'b0;
        end else if (!active) begin
            st <= S_IDLE;
        end else begin
            case (st)
                S_IDLE: if (!line) begin
                    st   <= S_START;
                    tcnt <= '0;
                end
                S_START: if (tick) begin
                    if (tcnt == T_MID) begin
                        tcnt <= '0;
                        if (line) st <= S_IDLE;
                        else begin
                            st      <= S_DATA;
                            bidx    <= '0;
                            shreg   <= '0;
                            par_acc <= 1'b0;
                        end
                    end else tcnt <= tcnt + 1'b1;
                end
                S_DATA: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (sample) begin
                        shreg[bidx] <= line;
                        par_acc     <= par_acc ^ line;
                        bidx        <= bidx + 1'b1;
                        if (bidx == nbits - 1'b1) st <= has_par ? S_PAR : S_STOP1;
                    end
                end
                S_PAR: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (sample) begin
                        pbit <= line;
                        st   <= S_STOP1;
                    end
                end
                S_STOP1: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (sample) begin
                        stop_bad <= !line;
                        if (two_stop) st <= S_STOP2;
                        else          st <= line ? S_IDLE : S_WAITHI;
                    end
                end
                S_STOP2: if (tick) begin
                    tcnt <= tcnt + 1'b1;
                    if (sample) st <= line ? S_IDLE : S_WAITHI;
                end
                S_WAITHI: if (line) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Registered word and one-cycle frame events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word    <= '0;
            word_we    <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            overrun    <= 1'b0;
            match_hit  <= 1'b0;
        end else begin
            if (frame_done) rx_word <= shreg;
            word_we    <= frame_done && !buf_full;
            overrun    <= frame_done && buf_full;
            frame_err  <= frame_done && stop_fail;
            parity_err <= frame_done && has_par && (pbit != exp_par);
            match_hit  <= frame_done && (shreg == match_word);
        end
    end

    // R2: bits beyond the word length of a delivered word are zero.
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |-> ((rx_word >> $past(nbits)) == '0));

    // R12: a disabled receiver delivers nothing on the next cycle.
    a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !(word_we || frame_err || parity_err || overrun || match_hit));
endmodule

// File: rtl/rx_idle_monitor.sv
// Line watch: counts a continuous low line for break detection, and counts
// quiet bit periods after a frame for the receiver timeout.
module rx_idle_monitor import uart_rx_pkg::*; #(
    parameter int TO_W     = 6,
    parameter int BRK_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            line,
    input  logic            tick,
    input  logic            frame_done,
    input  logic            restart,
    input  logic [TO_W-1:0] timeout_bits,
    output logic            line_break,
    output logic            rx_timeout
);
    localparam int BRK_TICKS = BRK_BITS * OSR;
    localparam int CW = $clog2(BRK_TICKS);
    localparam int TW = $clog2(OSR);

    logic [CW-1:0]   brk_cnt;
    logic            brk_done;
    logic [TW-1:0]   sub_cnt;
    logic [TO_W-1:0] bit_cnt;
    logic            armed;

    // Break: ticks of continuous low line, fires once per low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_cnt    <= '0;
            brk_done   <= 1'b0;
            line_break <= 1'b0;
        end else begin
            line_break <= 1'b0;
            if (!active || line) begin
                brk_cnt  <= '0;
                brk_done <= 1'b0;
            end else if (tick && !brk_done) begin
                if (brk_cnt == CW'(BRK_TICKS - 1)) begin
                    line_break <= 1'b1;
                    brk_done   <= 1'b1;
                end else brk_cnt <= brk_cnt + 1'b1;
            end
        end
    end

    // Timeout: armed by a finished frame, counts whole quiet bit periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            sub_cnt    <= '0;
            bit_cnt    <= '0;
            rx_timeout <= 1'b0;
        end else begin
            rx_timeout <= 1'b0;
            if (!active || (timeout_bits == '0) || restart) begin
                armed <= 1'b0;
            end else if (frame_done) begin
                armed   <= 1'b1;
                sub_cnt <= '0;
                bit_cnt <= '0;
            end else if (armed && tick) begin
                sub_cnt <= sub_cnt + 1'b1;
                if (sub_cnt == TW'(OSR - 1)) begin
                    if ({1'b0, bit_cnt} + 1'b1 >= {1'b0, timeout_bits}) begin
                        rx_timeout <= 1'b1;
                        armed      <= 1'b0;
                    end else bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
// Top of the serial receiver: line conditioning, sample-rate divider,
// frame engine and line watch. Assumes the downstream buffer samples
// rx_word on rx_word_we.
module uart_rx_core #(
    parameter int DW       = 9,
    parameter int PW       = 16,
    parameter int TO_W     = 6,
    parameter int FILT_LEN = 8,
    parameter int BRK_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_pin,
    input  logic            tx_loop,
    input  logic            loop_en,
    input  logic            filt_en,
    input  logic            glob_en,
    input  logic            rx_en,
    input  logic [PW-1:0]   prescale,
    input  logic [3:0]      word_len,
    input  logic [2:0]      parity_mode,
    input  logic            two_stop,
    input  logic [TO_W-1:0] timeout_bits,
    input  logic [DW-1:0]   match_word,
    input  logic            buf_full,
    output logic [DW-1:0]   rx_word,
    output logic            rx_word_we,
    output logic            frame_err,
    output logic            parity_err,
    output logic            overrun,
    output logic            line_break,
    output logic            match_hit,
    output logic            rx_timeout
);
    logic active, line, tick, restart, frame_done;

    assign active = glob_en && rx_en;

    rx_line_cond #(.FILT_LEN(FILT_LEN)) u_line (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_en(loop_en), .filt_en(filt_en), .line(line));

    rx_tick_gen #(.PW(PW)) u_tick (
        .clk(clk), .rst_n(rst_n), .prescale(prescale),
        .restart(restart), .tick(tick));

    rx_frame_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .line(line), .tick(tick),
        .word_len(word_len), .parity_mode(parity_mode), .two_stop(two_stop),
        .match_word(match_word), .buf_full(buf_full), .restart(restart),
        .frame_done(frame_done), .rx_word(rx_word), .word_we(rx_word_we),
        .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun),
        .match_hit(match_hit));

    rx_idle_monitor #(.TO_W(TO_W), .BRK_BITS(BRK_BITS)) u_mon (
        .clk(clk), .rst_n(rst_n), .active(active), .line(line), .tick(tick),
        .frame_done(frame_done), .restart(restart), .timeout_bits(timeout_bits),
        .line_break(line_break), .rx_timeout(rx_timeout));

    // R6: overrun and a word strobe never occur together.
    a_r6_no_store_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        !(overrun && rx_word_we));

    // R6: an overrun only follows a cycle where the buffer reported full.
    a_r6_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(buf_full));

    // R8: a break pulse never coincides with a delivered word.
    a_r8_break_apart: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |-> !rx_word_we);

    // R9: the timeout is a single-cycle pulse.
    a_r9_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> !rx_timeout);
endmodule

// File: tb/uart_rx_core_tb_top.sv
// Self-checking bench: a behavioural model queues the expected events for
// each frame it drives; every clock, any observed pulse is popped and compared.
module uart_rx_core_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pin = 1'b1, tx_loop = 1'b1, loop_en = 1'b0, filt_en = 1'b0;
    logic glob_en = 1'b1, rx_en = 1'b1, two_stop = 1'b0, buf_full = 1'b0;
    logic [15:0] prescale = 16'd1;
    logic [3:0]  word_len = 4'd8;
    logic [2:0]  parity_mode = 3'b000;
    logic [5:0]  timeout_bits = 6'd0;
    logic [8:0]  match_word = 9'h1FF;
    logic [8:0]  rx_word;
    logic rx_word_we, frame_err, parity_err, overrun, line_break, match_hit, rx_timeout;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    use_loop = 0;
    string cur_req = "R1";
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    uart_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_en(loop_en), .filt_en(filt_en), .glob_en(glob_en), .rx_en(rx_en),
        .prescale(prescale), .word_len(word_len), .parity_mode(parity_mode),
        .two_stop(two_stop), .timeout_bits(timeout_bits), .match_word(match_word),
        .buf_full(buf_full), .rx_word(rx_word), .rx_word_we(rx_word_we),
        .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun),
        .line_break(line_break), .match_hit(match_hit), .rx_timeout(rx_timeout));

    // Event packing: {brk, to, match, ovr, perr, ferr, we, word[8:0]}.
    function automatic logic [15:0] ev(logic [8:0] w, bit we, bit fe, bit pe,
                                       bit ov, bit mt, bit brk, bit to);
        return {brk, to, mt, ov, pe, fe, we, we ? w : 9'h000};
    endfunction

    // Compare every observed pulse against the model queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] obs;
            obs = ev(rx_word, rx_word_we, frame_err, parity_err, overrun,
                     match_hit, line_break, rx_timeout);
            if (obs != 16'h0) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected event %h, expected none", cur_req, obs);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if (obs !== e) begin
                        errors++;
                        $display("FAIL %s: event %h, expected %h", cur_req, obs, e);
                    end
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int bt();
        return 16 * (int'(prescale) + 1);
    endfunction

    task automatic drive(input bit v);
        if (use_loop) tx_loop = v; else rx_pin = v;
    endtask

    task automatic put_bit(input bit v);
        drive(v);
        wait_cyc(bt());
    endtask

    // Glitched 1 bit: a 7-clock low pulse across the mid-bit (prescale 0).
    task automatic put_glitch();
        drive(1'b1); wait_cyc(6);
        drive(1'b0); wait_cyc(7);
        drive(1'b1); wait_cyc(3);
    endtask

    // Drive one frame with the current settings and queue its expected event.
    task automatic send_frame(input logic [8:0] data, input bit bad_par,
                              input bit bad_s1, input bit bad_s2,
                              input logic [8:0] gl_mask, input bit gl_seen,
                              input bit expect_any);
        int nb;
        logic [8:0] w, ew;
        bit p, haspar, fe, pe;
        nb = (word_len < 5) ? 5 : (word_len > 9) ? 9 : int'(word_len);
        w  = data & 9'((1 << nb) - 1);
        haspar = (parity_mode == 3'b001) || (parity_mode == 3'b010) ||
                 (parity_mode == 3'b100) || (parity_mode == 3'b101);
        case (parity_mode)
            3'b001:  p = ~(^w);
            3'b010:  p = ^w;
            3'b101:  p = 1'b1;
            default: p = 1'b0;
        endcase
        ew = gl_seen ? (w & ~gl_mask) : w;
        fe = bad_s1 || (two_stop && bad_s2);
        pe = haspar && bad_par;
        if (expect_any)
            exp_q.push_back(ev(ew, !buf_full, fe, pe, buf_full, ew == match_word, 0, 0));
        put_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (gl_mask[i]) put_glitch();
            else            put_bit(w[i]);
        end
        if (haspar) put_bit(p ^ bad_par);
        put_bit(!bad_s1);
        if (two_stop) put_bit(!bad_s2);
        put_bit(1'b1);
        put_bit(1'b1);
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected events missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        // R1: reset state.
        checks++;
        if ({rx_word, rx_word_we, frame_err, parity_err, overrun, line_break,
             match_hit, rx_timeout} !== 16'h0) begin
            errors++;
            $display("FAIL R1: outputs %h, expected 0", {rx_word, rx_word_we, frame_err,
                     parity_err, overrun, line_break, match_hit, rx_timeout});
        end
        rst_n = 1'b1;
        wait_cyc(4);

        // R2, R13: basic 8-bit frames at prescale 1.
        cur_req = "R2";
        send_frame(9'h0A5, 0, 0, 0, 0, 0, 1);
        send_frame(9'h03C, 0, 0, 0, 0, 0, 1);
        word_len = 4'd5;  send_frame(9'h1F3, 0, 0, 0, 0, 0, 1);
        word_len = 4'd9;  send_frame(9'h1A5, 0, 0, 0, 0, 0, 1);
        word_len = 4'd2;  send_frame(9'h016, 0, 0, 0, 0, 0, 1);
        word_len = 4'd8;
        check_quiet("R2");

        // R3: parity codes, good and bad.
        cur_req = "R3";
        parity_mode = 3'b010; send_frame(9'h0B7, 0, 0, 0, 0, 0, 1);
                              send_frame(9'h0B7, 1, 0, 0, 0, 0, 1);
        parity_mode = 3'b001; send_frame(9'h031, 0, 0, 0, 0, 0, 1);
                              send_frame(9'h031, 1, 0, 0, 0, 0, 1);
        parity_mode = 3'b100; send_frame(9'h0FF, 1, 0, 0, 0, 0, 1);
        parity_mode = 3'b101; send_frame(9'h000, 0, 0, 0, 0, 0, 1);
        parity_mode = 3'b000;
        check_quiet("R3");

        // R4: stop bits.
        cur_req = "R4";
        two_stop = 1'b1;
        send_frame(9'h05A, 0, 0, 0, 0, 0, 1);
        send_frame(9'h05A, 0, 0, 1, 0, 0, 1);
        two_stop = 1'b0;
        send_frame(9'h0C3, 0, 1, 0, 0, 0, 1);
        check_quiet("R4");

        // R7: compare word.
        cur_req = "R7";
        match_word = 9'h05A;
        send_frame(9'h05A, 0, 0, 0, 0, 0, 1);
        send_frame(9'h05B, 0, 0, 0, 0, 0, 1);
        check_quiet("R7");

        // R6: overrun with buffer full.
        cur_req = "R6";
        buf_full = 1'b1; send_frame(9'h011, 0, 0, 0, 0, 0, 1);
        buf_full = 1'b0;
        check_quiet("R6");

        // R5: short false start.
        cur_req = "R5";
        rx_pin = 1'b0; wait_cyc(6);
        rx_pin = 1'b1; wait_cyc(3 * bt());
        check_quiet("R5");

        // R8: 14 bit periods low: framing error on word 0, then one break.
        cur_req = "R8";
        exp_q.push_back(ev(9'h000, 1, 1, 0, 0, 0, 0, 0));
        exp_q.push_back(ev(9'h000, 0, 0, 0, 0, 0, 1, 0));
        rx_pin = 1'b0; wait_cyc(14 * bt());
        rx_pin = 1'b1; wait_cyc(3 * bt());
        check_quiet("R8");

        // R9: timeout three bit periods after a frame, once only.
        cur_req = "R9";
        timeout_bits = 6'd3;
        exp_q.push_back(ev(9'h077, 1, 0, 0, 0, 0, 0, 0));
        exp_q.push_back(ev(9'h000, 0, 0, 0, 0, 0, 0, 1));
        send_frame(9'h077, 0, 0, 0, 0, 0, 0);
        wait_cyc(6 * bt());
        check_quiet("R9");
        wait_cyc(12 * bt());
        check_quiet("R9");
        timeout_bits = 6'd0;

        // R10: loopback reads tx_loop, ignores the pin.
        cur_req = "R10";
        loop_en = 1'b1; wait_cyc(4);
        rx_pin = 1'b0;
        use_loop = 1;
        send_frame(9'h0E1, 0, 0, 0, 0, 0, 1);
        use_loop = 0;
        rx_pin = 1'b1; wait_cyc(4);
        loop_en = 1'b0; wait_cyc(4);
        check_quiet("R10");
        use_loop = 1;
        send_frame(9'h0E1, 0, 0, 0, 0, 0, 0);
        use_loop = 0;
        check_quiet("R10");

        // R11: glitch on data bit 1 at prescale 0, seen unfiltered only.
        cur_req = "R11";
        prescale = 16'd0;
        send_frame(9'h00F, 0, 0, 0, 9'h002, 1, 1);
        filt_en = 1'b1; wait_cyc(16);
        send_frame(9'h00F, 0, 0, 0, 9'h002, 0, 1);
        filt_en = 1'b0; prescale = 16'd1; wait_cyc(16);
        check_quiet("R11");

        // R12: either enable low blocks reception.
        cur_req = "R12";
        rx_en = 1'b0;   send_frame(9'h0AA, 0, 0, 0, 0, 0, 0);
        rx_en = 1'b1;
        check_quiet("R12");
        glob_en = 1'b0; send_frame(9'h055, 0, 0, 0, 0, 0, 0);
        glob_en = 1'b1; wait_cyc(4);
        check_quiet("R12");
        send_frame(9'h055, 0, 0, 0, 0, 0, 1);
        check_quiet("R12");

        finish_run();
    end
endmodule